// File: doc/BRIEF.md
# QPSK Decision-Directed Carrier Phase Loop

This block recovers the unknown carrier phase of a QPSK symbol stream. It takes one complex matched-filter output per symbol, as signed fixed-point I and Q values with a valid strobe. Each sample is rotated back by the loop's current phase estimate, sliced to the nearest constellation corner, and compared with that corner to form a phase error. A proportional-plus-integral filter turns the error into a phase step, which is added to a wrapping phase accumulator. That accumulator sets the rotation applied to the next symbol.

The filter gains are fixed. They give a second-order loop with equivalent noise bandwidth 0.02 of the symbol rate and damping 0.7071. The gains already allow for the detector slope of 2 that ideal (±1, ±1) points produce. The loop can come to rest at any of four phases spaced a quarter turn apart. Resolving that ambiguity, for example with differential coding, is left to logic downstream. The filter output is brought out so that acquisition can be watched.

Input samples use 8 fractional bits, so 256 represents 1.0 and the ideal points are (±256, ±256). Matched filtering, timing recovery and mixing down to baseband are outside this block.

Top module: `qpsk_phase_loop`

## Requirements
- R1: A synchronous active-low reset clears the phase accumulator, the integrator and every output register: out_valid, rot_i, rot_q, dec and filt_out all read zero.
- R2: A symbol accepted on a clock edge with in_valid high has its results on the outputs after that edge, with out_valid high for exactly that one cycle.
- R3: rot_i = floor((I·c + Q·s)/1024) and rot_q = floor((Q·c − I·s)/1024). Here s and c are the sine and cosine of the phase, scaled by 1024 and rounded. They are read from a quarter-wave table with 256 steps per turn, addressed by accumulator bits [15:8]. At phase zero the output equals the input exactly.
- R4: dec[1] is 1 when rot_i is negative and dec[0] is 1 when rot_q is negative. Zero counts as non-negative.
- R5: The phase error is e = rot_q·sgn(rot_i) − rot_i·sgn(rot_q), where sgn(x) = +1 for x ≥ 0 and −1 otherwise.
- R6: filt_out = floor((4331·e + A)/4096), where A is the integrator value before this symbol. After the symbol, A increases by 116·e.
- R7: After each symbol the 16-bit phase accumulator adds filt_out modulo 65536, where 65536 is one full turn. A negative step wraps it to the top of the range.
- R8: While in_valid is low, out_valid is low and rot_i, rot_q, dec, filt_out, the accumulator and the integrator all hold their values.
- R9: With a fixed carrier phase offset of 30 degrees, the de-rotated points settle within 1200 symbols onto corners of magnitude about 256 per axis, with |rot_i| and |rot_q| matching to within 30.
- R10: With a carrier that drifts by 0.3 degrees per symbol, the loop tracks the drift through many accumulator wraps and the de-rotated points meet the same settling bound as R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Marks a new symbol sample |
| in_i | input | 12 | In-phase sample, signed, 8 fractional bits |
| in_q | input | 12 | Quadrature sample, signed, 8 fractional bits |
| out_valid | output | 1 | Registered results are for a new symbol |
| rot_i | output | 13 | De-rotated in-phase value, signed |
| rot_q | output | 13 | De-rotated quadrature value, signed |
| dec | output | 2 | Hard decision: bit 1 is the I sign, bit 0 is the Q sign |
| filt_out | output | 16 | Loop filter output, as a signed phase step in accumulator units |

## Verification
A wrong accumulator value shows up on the next valid symbol as a rotated rot_i/rot_q pair, and from then on as a changed filt_out. A wrong integrator value shows up the same way, through filt_out, on the next symbol. The exact-value vectors are therefore each applied straight after reset at phase zero, where every output can be derived by hand. The directed sequences then bring the integrator's contribution and a wrapped accumulator to the ports one symbol after each is created. Faults that only perturb the loop dynamics, such as a wrong gain or a wrong table entry, show up over hundreds of symbols as a failure to settle in the lock and drift runs.

// File: rtl/qpl_pkg.sv
// Package: shared widths and fixed-point constants of the QPSK phase loop.
// Assumes inputs carry 8 fractional bits and 1.0 in the trig table is 1024.
package qpl_pkg;
    localparam int IN_W_D      = 12;   // input sample width
    localparam int PH_W_D      = 16;   // phase accumulator width (one turn)
    localparam int LUT_AW_D    = 8;    // phase bits used to address the table
    localparam int TRIG_FRAC_D = 10;   // fractional bits of sine/cosine
    localparam int GAIN_FRAC_D = 12;   // fractional bits of loop gains
    localparam int ACC_W_D     = 32;   // loop filter arithmetic width
    localparam int K1_D        = 4331; // proportional gain, scaled
    localparam int K2_D        = 116;  // integral gain, scaled
endpackage

// File: rtl/qpl_sincos.sv
// Module: sine and cosine of a phase word from a quarter-wave table.
// Assumes LUT_AW >= 3; values are rounded and scaled by 2**TRIG_FRAC.
module qpl_sincos #(
    parameter int PH_W      = 16,
    parameter int LUT_AW    = 8,
    parameter int TRIG_FRAC = 10,
    localparam int TW       = TRIG_FRAC + 2
) (
    input  logic [PH_W-1:0]        phase,
    output logic signed [TW-1:0]   sin_v,
    output logic signed [TW-1:0]   cos_v
);
    localparam int QN = 1 << (LUT_AW - 2);
    localparam logic [LUT_AW-2:0] QN_V = (LUT_AW-1)'(QN);
    localparam real TWO_PI = 6.283185307179586;

    logic signed [TW-1:0] quarter [0:QN];
    logic [LUT_AW-1:0] idx_s;
    logic [LUT_AW-1:0] idx_c;

    // Quarter-wave table, one entry per step from 0 to 90 degrees inclusive.
    for (genvar k = 0; k <= QN; k++) begin : g_tab
        localparam real ANG = TWO_PI * k / (4.0 * QN);
        assign quarter[k] = TW'($rtoi($sin(ANG) * (2.0 ** TRIG_FRAC) + 0.5));
    end

    // Fold a full-circle index onto the quarter table.
    function automatic logic signed [TW-1:0] fold(input logic [LUT_AW-1:0] a);
        logic [LUT_AW-2:0] off;
        logic [LUT_AW-2:0] mir;
        off = {1'b0, a[LUT_AW-3:0]};
        mir = QN_V - off;
        case (a[LUT_AW-1:LUT_AW-2])
            2'd0:    fold = quarter[off];
            2'd1:    fold = quarter[mir];
            2'd2:    fold = -quarter[off];
            default: fold = -quarter[mir];
        endcase
    endfunction

    assign idx_s = phase[PH_W-1 -: LUT_AW];
    assign idx_c = idx_s + LUT_AW'(QN);
    assign sin_v = fold(idx_s);
    assign cos_v = fold(idx_c);
endmodule

// File: rtl/qpl_derotate.sv
// Module: complex multiply of a sample by exp(-j*phase).
// Assumes sin/cos are scaled by 2**TRIG_FRAC; the result is floored.
module qpl_derotate #(
    parameter int IN_W      = 12,
    parameter int TRIG_FRAC = 10,
    localparam int TW       = TRIG_FRAC + 2,
    localparam int OUT_W    = IN_W + 1
) (
    input  logic signed [IN_W-1:0]  in_i,
    input  logic signed [IN_W-1:0]  in_q,
    input  logic signed [TW-1:0]    sin_v,
    input  logic signed [TW-1:0]    cos_v,
    output logic signed [OUT_W-1:0] rot_i,
    output logic signed [OUT_W-1:0] rot_q
);
    localparam int PW = IN_W + TW;

    logic signed [PW-1:0] p_ic, p_qs, p_qc, p_is;
    logic signed [PW:0]   sum_i, sum_q;

    // Four partial products, then sign-extended sum and difference.
    always_comb begin
        p_ic  = in_i * cos_v;
        p_qs  = in_q * sin_v;
        p_qc  = in_q * cos_v;
        p_is  = in_i * sin_v;
        sum_i = $signed({p_ic[PW-1], p_ic}) + $signed({p_qs[PW-1], p_qs});
        sum_q = $signed({p_qc[PW-1], p_qc}) - $signed({p_is[PW-1], p_is});
    end

    assign rot_i = sum_i[TRIG_FRAC +: OUT_W];
    assign rot_q = sum_q[TRIG_FRAC +: OUT_W];
endmodule

// File: rtl/qpl_slicer.sv
// Module: nearest-corner QPSK decision and decision-directed phase error.
// Assumes zero is treated as a positive value in both axes.
module qpl_slicer #(
    parameter int OUT_W  = 13,
    localparam int ERR_W = OUT_W + 1
) (
    input  logic signed [OUT_W-1:0] rot_i,
    input  logic signed [OUT_W-1:0] rot_q,
    output logic [1:0]              dec,
    output logic signed [ERR_W-1:0] err
);
    logic signed [ERR_W-1:0] ext_i, ext_q, term_q, term_i;

    // Sign-weighted cross terms of the rotated sample.
    always_comb begin
        ext_i  = {rot_i[OUT_W-1], rot_i};
        ext_q  = {rot_q[OUT_W-1], rot_q};
        term_q = rot_i[OUT_W-1] ? -ext_q : ext_q;
        term_i = rot_q[OUT_W-1] ? -ext_i : ext_i;
        err    = term_q - term_i;
        dec    = {rot_i[OUT_W-1], rot_q[OUT_W-1]};
    end
endmodule

// File: rtl/qpl_loop.sv
// Module: proportional-plus-integral loop filter and wrapping phase accumulator.
// Assumes state advances only on valid symbols; gains carry GAIN_FRAC bits.
module qpl_loop #(
    parameter int ERR_W     = 14,
    parameter int PH_W      = 16,
    parameter int ACC_W     = 32,
    parameter int GAIN_FRAC = 12,
    parameter int K1        = 4331,
    parameter int K2        = 116
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sym_valid,
    input  logic signed [ERR_W-1:0] err,
    output logic [PH_W-1:0]         phase,
    output logic signed [PH_W-1:0]  step
);
    localparam logic signed [ACC_W-1:0] K1_S = ACC_W'(K1);
    localparam logic signed [ACC_W-1:0] K2_S = ACC_W'(K2);

    logic signed [ACC_W-1:0] integ;
    logic signed [ACC_W-1:0] err_x, prop, v_full;

    // Filter output from the proportional term and the prior integrator.
    always_comb begin
        err_x  = ACC_W'(err);
        prop   = err_x * K1_S;
        v_full = prop + integ;
        step   = v_full[GAIN_FRAC +: PH_W];
    end

    // Integrator and phase accumulator advance on each valid symbol.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            integ <= '0;
            phase <= '0;
        end else if (sym_valid) begin
            integ <= integ + err_x * K2_S;
            phase <= phase + step;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (phase == '0 && integ == '0));

    p_idle_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_valid |=> ($stable(phase) && $stable(integ)));
endmodule

// File: rtl/qpsk_phase_loop.sv
// Module: QPSK decision-directed carrier phase loop (top).
// Assumes one matched-filter sample per symbol with 8 fractional bits;
// results are registered one cycle after each accepted symbol.
module qpsk_phase_loop
    import qpl_pkg::*;
#(
    parameter int IN_W      = IN_W_D,
    parameter int PH_W      = PH_W_D,
    parameter int LUT_AW    = LUT_AW_D,
    parameter int TRIG_FRAC = TRIG_FRAC_D,
    parameter int GAIN_FRAC = GAIN_FRAC_D,
    parameter int ACC_W     = ACC_W_D,
    parameter int K1        = K1_D,
    parameter int K2        = K2_D,
    localparam int OUT_W    = IN_W + 1,
    localparam int ERR_W    = OUT_W + 1,
    localparam int TW       = TRIG_FRAC + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_i,
    input  logic signed [IN_W-1:0]  in_q,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] rot_i,
    output logic signed [OUT_W-1:0] rot_q,
    output logic [1:0]              dec,
    output logic signed [PH_W-1:0]  filt_out
);
    logic [PH_W-1:0]         phase;
    logic signed [TW-1:0]    sin_v, cos_v;
    logic signed [OUT_W-1:0] ri_c, rq_c;
    logic [1:0]              dec_c;
    logic signed [ERR_W-1:0] err_c;
    logic signed [PH_W-1:0]  step_c;

    qpl_sincos #(.PH_W(PH_W), .LUT_AW(LUT_AW), .TRIG_FRAC(TRIG_FRAC)) u_trig (
        .phase(phase), .sin_v(sin_v), .cos_v(cos_v)
    );

    qpl_derotate #(.IN_W(IN_W), .TRIG_FRAC(TRIG_FRAC)) u_rot (
        .in_i(in_i), .in_q(in_q), .sin_v(sin_v), .cos_v(cos_v),
        .rot_i(ri_c), .rot_q(rq_c)
    );

    qpl_slicer #(.OUT_W(OUT_W)) u_slice (
        .rot_i(ri_c), .rot_q(rq_c), .dec(dec_c), .err(err_c)
    );

    qpl_loop #(
        .ERR_W(ERR_W), .PH_W(PH_W), .ACC_W(ACC_W),
        .GAIN_FRAC(GAIN_FRAC), .K1(K1), .K2(K2)
    ) u_loop (
        .clk(clk), .rst_n(rst_n), .sym_valid(in_valid), .err(err_c),
        .phase(phase), .step(step_c)
    );

    // Output registers load once per accepted symbol and hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            rot_i     <= '0;
            rot_q     <= '0;
            dec       <= '0;
            filt_out  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                rot_i    <= ri_c;
                rot_q    <= rq_c;
                dec      <= dec_c;
                filt_out <= step_c;
            end
        end
    end

    p_valid_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(filt_out) && $stable(rot_i)));

    p_dec_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (dec == {rot_i[OUT_W-1], rot_q[OUT_W-1]}));

    p_trig_norm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(sin_v) * int'(sin_v) + int'(cos_v) * int'(cos_v)) >
            (1 << (2 * TRIG_FRAC)) - (1 << (TRIG_FRAC + 2))) &&
        ((int'(sin_v) * int'(sin_v) + int'(cos_v) * int'(cos_v)) <
            (1 << (2 * TRIG_FRAC)) + (1 << (TRIG_FRAC + 2))));

    p_diag_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (((ri_c < 0) ? -ri_c : ri_c) == ((rq_c < 0) ? -rq_c : rq_c))
            |-> (err_c == '0));
endmodule

// File: tb/qpsk_phase_loop_test.sv
`timescale 1ns/1ps
module qpsk_phase_loop_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [11:0] in_i = '0;
    logic signed [11:0] in_q = '0;
    logic out_valid;
    logic signed [12:0] rot_i, rot_q;
    logic [1:0] dec;
    logic signed [15:0] filt_out;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    qpsk_phase_loop uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .out_valid(out_valid), .rot_i(rot_i), .rot_q(rot_q), .dec(dec),
        .filt_out(filt_out)
    );

    // Columns: in_i, in_q, rot_i, rot_q, dec, filt_out (each applied at phase 0)
    localparam int VEC [8][6] = '{
        '{ 256,   256,   256,   256, 0,   0},
        '{ 256,   300,   256,   300, 0,  46},
        '{-256,   300,  -256,   300, 2, -47},
        '{-300,  -256,  -300,  -256, 3, -47},
        '{ 300,  -256,   300,  -256, 1,  46},
        '{   0,     0,     0,     0, 0,   0},
        '{ 100,   -50,   100,   -50, 1,  52},
        '{-2048, 2047, -2048,  2047, 2,   1}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(input int i, input int q);
        @(negedge clk);
        in_i = 12'(i);
        in_q = 12'(q);
        in_valid = 1'b1;
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_i = 12'(k * 37 - 900);
            in_q = 12'(500 - k * 91);
        end
    endtask

    function automatic int rnd(input real x);
        return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
    endfunction

    function automatic int iabs(input int x);
        return (x < 0) ? -x : x;
    endfunction

    // Drive rotated corners; count settling violations over the final window.
    task automatic run_track(input string req, input int n, input real ph0,
                             input real dph);
        int bad = 0;
        for (int k = 0; k < n; k++) begin
            int d = (k * 5 + k / 3) % 4;
            real ang = ph0 + dph * k;
            real a = (d >= 2) ? -256.0 : 256.0;
            real b = (d % 2 == 1) ? -256.0 : 256.0;
            send(rnd(a * $cos(ang) - b * $sin(ang)), rnd(b * $cos(ang) + a * $sin(ang)));
            if (k >= n - 100) begin
                if (iabs(iabs(int'(rot_i)) - iabs(int'(rot_q))) > 30 ||
                    iabs(int'(rot_i)) < 200 || iabs(int'(rot_q)) < 200)
                    bad++;
            end
        end
        check(req, bad, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R2 watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        // R1: state after reset
        do_reset();
        #1;
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 rot_i", int'(rot_i), 0);
        check("R1 filt_out", int'(filt_out), 0);
        check("R1 dec", int'(dec), 0);

        // R3 R4 R5 R6 R2: exact vectors at phase zero
        for (int v = 0; v < 8; v++) begin
            do_reset();
            send(VEC[v][0], VEC[v][1]);
            check("R2 out_valid", int'(out_valid), 1);
            check("R3 rot_i", int'(rot_i), VEC[v][2]);
            check("R3 rot_q", int'(rot_q), VEC[v][3]);
            check("R4 dec", int'(dec), VEC[v][4]);
            check("R5/R6 filt_out", int'(filt_out), VEC[v][5]);
        end

        // R8: idle cycles change nothing
        do_reset();
        send(256, 300);
        idle(5);
        #1;
        check("R8 out_valid low", int'(out_valid), 0);
        check("R8 filt held", int'(filt_out), 46);
        check("R8 rot_q held", int'(rot_q), 300);
        // R6: integrator alone (zero error) after idle
        send(0, 0);
        check("R6 integ only", int'(filt_out), 1);
        // R7: accumulator 47 still maps to table index 0
        send(256, 0);
        check("R7 rot_i", int'(rot_i), 256);
        check("R7 rot_q", int'(rot_q), 0);
        check("R6 filt", int'(filt_out), -270);
        // R7: phase wrapped to 65313 -> index 255
        send(256, 0);
        check("R7 wrap rot_i", int'(rot_i), 256);
        check("R7 wrap rot_q", int'(rot_q), 6);
        check("R7 wrap filt", int'(filt_out), -271);
        check("R4 wrap dec", int'(dec), 0);

        // R1: reset clears integrator and phase after activity
        do_reset();
        send(256, 300);
        check("R1 cleared filt", int'(filt_out), 46);
        check("R1 cleared rot_q", int'(rot_q), 300);

        // R9: static 30 degree offset
        do_reset();
        run_track("R9 lock", 1200, 0.5235987756, 0.0);

        // R10: frequency drift of 0.3 degrees per symbol
        do_reset();
        run_track("R10 drift", 2000, 0.0, 0.0052359878);
        idle(1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule